// File: doc/BRIEF.md
# Context-Switched 64-bit General Register File

This block holds the integer operand state of a 64-bit processor core. It provides thirty-one storage registers, numbered 0 to 30. It has two combinational read ports and one clocked write port. Each port takes a 5-bit register number and a one-bit context flag.

Register number 31 has no storage of its own in the general array. With the context flag low it acts as a constant zero source, and writes to it are thrown away. With the context flag high it selects a separate stack pointer register, which can be both read and written. Decode logic upstream decides which context an operand uses and drives the flag. The program counter is kept elsewhere and changes only through the branch path, so no register number reaches it.

Top module: `ctx_regfile`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), registers 0 to 30 read as zero and the stack pointer reads as the parameter SP_INIT.
- R2: With wr_en high, a write to register number 0 to 30 stores wr_data at the rising clock edge. Both read ports return the new value from that edge on.
- R3: With wr_en low, no register and not the stack pointer changes, whatever wr_sel, wr_sp_ctx and wr_data hold.
- R4: A read of number 31 with its context flag low (0) returns zero on that port.
- R5: A write to number 31 with wr_sp_ctx low is discarded. It leaves the stack pointer and every one of registers 0 to 30 unchanged.
- R6: A read of number 31 with its context flag high (1) returns the stack pointer.
- R7: A write to number 31 with wr_sp_ctx high loads the stack pointer at the rising edge and changes no register 0 to 30.
- R8: The two read ports are independent and combinational. Each output follows its own number and flag within the same cycle.
- R9: A read of the register being written in the same cycle returns the value held before the edge; there is no write-to-read bypass.
- R10: For numbers 0 to 30 the context flag has no effect on reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_sel | input | 5 | Register number for read port 0 |
| rd0_sp_ctx | input | 1 | Read port 0 context: 1 maps number 31 to the stack pointer |
| rd0_data | output | 64 | Read port 0 data |
| rd1_sel | input | 5 | Register number for read port 1 |
| rd1_sp_ctx | input | 1 | Read port 1 context: 1 maps number 31 to the stack pointer |
| rd1_data | output | 64 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Register number for the write port |
| wr_sp_ctx | input | 1 | Write context: 1 maps number 31 to the stack pointer |
| wr_data | input | 64 | Write data |

## Verification
Directed passes write distinct patterns into every storage register and read them back. This separates a correct address decode from aliasing between neighbouring numbers. Number 31 is tried in all four combinations of read and write context. The results distinguish the zero source, the discarded write and the stack pointer, and show whether a dropped write leaks into the stack pointer or into register 30. Same-cycle read-while-write and disabled writes with live data expose any bypass or enable fault. A long pseudo-random phase with both ports busy checks the ports' independence against a behavioural model on every cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int SEL_W   = 5;
    localparam int NUM_GPR = 31;
    localparam int ZR_IDX  = 31;
    localparam int NUM_RD  = 2;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             sp_ctx;
    } rf_spec_t;
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode
    import rf_pkg::*;
#(
    parameter int GPR_CNT = NUM_GPR
) (
    input  logic               wr_en,
    input  rf_spec_t           wr_spec,
    output logic [GPR_CNT-1:0] gpr_we,
    output logic               sp_we
);
    logic is_top;

    always_comb begin
        is_top = (wr_spec.sel == SEL_W'(ZR_IDX));
        sp_we  = wr_en && is_top && wr_spec.sp_ctx;
    end

    for (genvar i = 0; i < GPR_CNT; i++) begin : g_dec
        always_comb begin
            gpr_we[i] = wr_en && (wr_spec.sel == SEL_W'(i));
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int GPR_CNT = NUM_GPR
) (
    input  rf_spec_t                          spec,
    input  logic [GPR_CNT-1:0][DATA_W-1:0]    gpr_q,
    input  logic [DATA_W-1:0]                 sp_q,
    output logic [DATA_W-1:0]                 data
);
    always_comb begin
        data = '0;
        if (spec.sel == SEL_W'(ZR_IDX)) begin
            data = spec.sp_ctx ? sp_q : '0;
        end else begin
            for (int i = 0; i < GPR_CNT; i++) begin
                if (spec.sel == SEL_W'(i)) begin
                    data = gpr_q[i];
                end
            end
        end
    end
endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile
    import rf_pkg::*;
#(
    parameter int                DATA_W  = 64,
    parameter logic [DATA_W-1:0] SP_INIT = 64'h0000_0000_0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd0_sel,
    input  logic              rd0_sp_ctx,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [SEL_W-1:0]  rd1_sel,
    input  logic              rd1_sp_ctx,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_sp_ctx,
    input  logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic [NUM_GPR-1:0][DATA_W-1:0] gpr;
        logic [DATA_W-1:0]              sp;
    } rf_state_t;

    rf_state_t             state_d, state_q;
    logic [NUM_GPR-1:0]    gpr_we;
    logic                  sp_we;
    logic [DATA_W-1:0]     sp_q;
    rf_spec_t              rd_spec [NUM_RD];
    logic [DATA_W-1:0]     rd_data [NUM_RD];

    assign sp_q = state_q.sp;

    rf_write_decode #(.GPR_CNT(NUM_GPR)) u_wdec (
        .wr_en   (wr_en),
        .wr_spec ('{sel: wr_sel, sp_ctx: wr_sp_ctx}),
        .gpr_we  (gpr_we),
        .sp_we   (sp_we)
    );

    always_comb begin
        rd_spec[0] = '{sel: rd0_sel, sp_ctx: rd0_sp_ctx};
        rd_spec[1] = '{sel: rd1_sel, sp_ctx: rd1_sp_ctx};
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.DATA_W(DATA_W), .GPR_CNT(NUM_GPR)) u_rd (
            .spec  (rd_spec[p]),
            .gpr_q (state_q.gpr),
            .sp_q  (state_q.sp),
            .data  (rd_data[p])
        );
    end

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_GPR; i++) begin
            if (gpr_we[i]) begin
                state_d.gpr[i] = wr_data;
            end
        end
        if (sp_we) begin
            state_d.sp = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.gpr <= '0;
            state_q.sp  <= SP_INIT;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/ctx_regfile_chk.sv
module ctx_regfile_chk
    import rf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  rd0_sel,
    input logic              rd0_sp_ctx,
    input logic [DATA_W-1:0] rd0_data,
    input logic [SEL_W-1:0]  rd1_sel,
    input logic              rd1_sp_ctx,
    input logic [DATA_W-1:0] rd1_data,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic              wr_sp_ctx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] sp_q
);
    localparam logic [SEL_W-1:0] TOP = SEL_W'(ZR_IDX);

    // R4
    zero_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd0_sp_ctx && rd0_sel == TOP) |-> (rd0_data == '0));

    // R4
    zero_rd1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd1_sp_ctx && rd1_sel == TOP) |-> (rd1_data == '0));

    // R6
    sp_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_sp_ctx && rd0_sel == TOP) |-> (rd0_data == sp_q));

    // R5
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sp_ctx && wr_sel == TOP) |=> $stable(sp_q));

    // R3
    idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(sp_q));

    // R7
    sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sp_ctx && wr_sel == TOP) |=> (sp_q == $past(wr_data)));

    // R2
    gpr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != TOP) |=>
            (rd0_sel != $past(wr_sel) || rd0_data == $past(wr_data)));
endmodule

bind ctx_regfile ctx_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd0_sel    (rd0_sel),
    .rd0_sp_ctx (rd0_sp_ctx),
    .rd0_data   (rd0_data),
    .rd1_sel    (rd1_sel),
    .rd1_sp_ctx (rd1_sp_ctx),
    .rd1_data   (rd1_data),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_sp_ctx  (wr_sp_ctx),
    .wr_data    (wr_data),
    .sp_q       (sp_q)
);

// File: tb/ctx_regfile_tb.sv
`timescale 1ns/1ps
module ctx_regfile_tb;
    localparam logic [63:0] SPI = 64'h0000_0000_0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
    logic        rd0_sp_ctx = 1'b0, rd1_sp_ctx = 1'b0, wr_sp_ctx = 1'b0, wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd0_data, rd1_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] m_gpr [31];
    logic [63:0] m_sp;

    always #2.5 clk = ~clk;

    ctx_regfile #(.DATA_W(64), .SP_INIT(SPI)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_sel(rd0_sel), .rd0_sp_ctx(rd0_sp_ctx), .rd0_data(rd0_data),
        .rd1_sel(rd1_sel), .rd1_sp_ctx(rd1_sp_ctx), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_sp_ctx(wr_sp_ctx), .wr_data(wr_data)
    );

    function automatic logic [63:0] model_rd(input logic [4:0] s, input logic c);
        if (s == 5'd31) return c ? m_sp : 64'd0;
        return m_gpr[s];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare reads before the edge, update model at the edge.
    task automatic step(input string tag,
                        input logic [4:0] s0, input logic c0,
                        input logic [4:0] s1, input logic c1,
                        input logic we, input logic [4:0] ws, input logic wc,
                        input logic [63:0] wd);
        rd0_sel = s0; rd0_sp_ctx = c0; rd1_sel = s1; rd1_sp_ctx = c1;
        wr_en = we; wr_sel = ws; wr_sp_ctx = wc; wr_data = wd;
        #1;
        check(tag, rd0_data, model_rd(s0, c0));
        check(tag, rd1_data, model_rd(s1, c1));
        @(posedge clk);
        if (we) begin
            if (ws != 5'd31) m_gpr[ws] = wd;
            else if (wc) m_sp = wd;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 31; i++) m_gpr[i] = '0;
        m_sp = SPI;

        // R1: reset values observed while reset is held
        @(negedge clk);
        rd0_sel = 5'd31; rd0_sp_ctx = 1'b1; rd1_sel = 5'd7; rd1_sp_ctx = 1'b0;
        #1;
        check("R1", rd0_data, SPI);
        check("R1", rd1_data, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: fill every storage register with a distinct pattern, alternating context
        for (int i = 0; i < 31; i++)
            step("R2", 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'(i), i[0],
                 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101_0101));
        for (int i = 0; i < 31; i++)
            step("R2", 5'(i), 1'b0, 5'(30 - i), 1'b0, 1'b0, 5'd0, 1'b0, 64'd0);

        // R10: context flag on reads of ordinary numbers has no effect
        for (int i = 0; i < 31; i += 5)
            step("R10", 5'(i), 1'b1, 5'(i), 1'b0, 1'b0, 5'd0, 1'b0, 64'd0);

        // R4: normal-context read of 31 is zero on both ports
        step("R4", 5'd31, 1'b0, 5'd31, 1'b0, 1'b0, 5'd0, 1'b0, 64'd0);

        // R6: stack context read of 31 gives the stack pointer
        step("R6", 5'd31, 1'b1, 5'd31, 1'b1, 1'b0, 5'd0, 1'b0, 64'd0);

        // R5: dropped write, then look at SP, register 30 and the zero source
        step("R5", 5'd30, 1'b0, 5'd31, 1'b1, 1'b1, 5'd31, 1'b0, 64'hDEAD_BEEF_0BAD_F00D);
        step("R5", 5'd30, 1'b0, 5'd31, 1'b1, 1'b0, 5'd0, 1'b0, 64'd0);
        step("R5", 5'd31, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 64'd0);

        // R7: load stack pointer, then read it and neighbouring storage
        step("R7", 5'd0, 1'b0, 5'd30, 1'b1, 1'b1, 5'd31, 1'b1, 64'h0000_7FFF_FFFF_FFF0);
        step("R7", 5'd31, 1'b1, 5'd30, 1'b0, 1'b0, 5'd0, 1'b0, 64'd0);
        step("R7", 5'd31, 1'b0, 5'd31, 1'b1, 1'b0, 5'd0, 1'b0, 64'd0);

        // R3: disabled writes with live data to a register and to SP
        step("R3", 5'd12, 1'b0, 5'd31, 1'b1, 1'b0, 5'd12, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R3", 5'd12, 1'b0, 5'd31, 1'b1, 1'b0, 5'd31, 1'b1, 64'h1234_5678_9ABC_DEF0);
        step("R3", 5'd12, 1'b0, 5'd31, 1'b1, 1'b0, 5'd0, 1'b0, 64'd0);

        // R9: read the register under write in the same cycle, then the new value
        step("R9", 5'd9, 1'b0, 5'd9, 1'b1, 1'b1, 5'd9, 1'b0, 64'h0F0F_0F0F_F0F0_F0F0);
        step("R9", 5'd31, 1'b1, 5'd9, 1'b0, 1'b1, 5'd31, 1'b1, 64'h0000_0000_00FF_0000);
        step("R9", 5'd31, 1'b1, 5'd9, 1'b0, 1'b0, 5'd0, 1'b0, 64'd0);

        // R10: write with stack context to an ordinary number lands in storage, SP untouched
        step("R10", 5'd4, 1'b0, 5'd31, 1'b1, 1'b1, 5'd4, 1'b1, 64'hCAFE_0000_0000_0004);
        step("R10", 5'd4, 1'b1, 5'd31, 1'b1, 1'b0, 5'd0, 1'b0, 64'd0);

        // R8: pseudo-random traffic on both ports, model compared every cycle
        for (int n = 0; n < 3000; n++)
            step("R8", 5'($urandom), 1'($urandom), 5'($urandom), 1'($urandom),
                 1'($urandom), 5'($urandom), 1'($urandom), {$urandom, $urandom});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule